// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block works out where execution goes next in a 16-bit code address space. Each cycle it takes the address of the instruction that follows the current one. It also takes a branch kind, the top three opcode bits, up to two operand bytes, the accumulator, the 16-bit data pointer and a taken flag that a separate condition unit supplies. From these it produces the next program counter.

In the same cycle, and with no dependence on the branch kind, it forms the effective address for a read of a constant table from code memory. That address is the accumulator plus either the data pointer or the following-instruction address.

Both results are registered. They appear one clock after a cycle in which `valid_i` is high. Instruction fetch, the return-address stack and the evaluation of branch conditions all belong to neighbouring blocks.

Top module: `pcu_next_pc`

## Requirements
- R1: While `rst_n` is low, and until the first accepted request, `next_pc_o`, `tbl_addr_o` and `valid_o` are all zero.
- R2: `valid_o` on a clock edge equals the `valid_i` sampled on the previous edge, and the results of a request appear exactly one clock after it is accepted.
- R3: With `kind_i` = 1 (relative) and `taken_i` = 1, `next_pc_o` = `follow_pc_i` + sign-extended `op_a_i`, modulo 2^16. Wrapping is possible in both directions.
- R4: With `kind_i` = 1 and `taken_i` = 0, `next_pc_o` = `follow_pc_i`.
- R5: With `kind_i` = 2 (page-absolute), `next_pc_o` bits 15:11 are `follow_pc_i` bits 15:11, bits 10:8 are `opc_hi_i`, and bits 7:0 are `op_a_i`.
- R6: With `kind_i` = 3 (long), `next_pc_o` = {`op_a_i`, `op_b_i`}: `op_a_i` is the high byte and `op_b_i` the low byte.
- R7: With `kind_i` = 4 (indirect), `next_pc_o` = `dptr_i` + zero-extended `acc_i`, modulo 2^16.
- R8: With `kind_i` = 0, 5, 6 or 7, `next_pc_o` = `follow_pc_i`, and `taken_i` has no effect.
- R9: For every branch kind, `tbl_addr_o` = zero-extended `acc_i` plus (`tbl_sel_i` = 1 ? `follow_pc_i` : `dptr_i`), modulo 2^16.
- R10: When `valid_i` is low, `next_pc_o` and `tbl_addr_o` hold their previous values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Request present this cycle |
| kind_i | input | 3 | Branch kind: 0 seq, 1 relative, 2 page, 3 long, 4 indirect |
| taken_i | input | 1 | Condition result for relative branches |
| follow_pc_i | input | 16 | Address of the following instruction |
| opc_hi_i | input | 3 | Upper opcode bits for page-absolute targets |
| op_a_i | input | 8 | First operand byte (offset, page low byte, or long high byte) |
| op_b_i | input | 8 | Second operand byte (long low byte) |
| acc_i | input | 8 | Accumulator |
| dptr_i | input | 16 | Data pointer |
| tbl_sel_i | input | 1 | Table base: 1 follow PC, 0 data pointer |
| valid_o | output | 1 | Results valid |
| next_pc_o | output | 16 | Next program counter |
| tbl_addr_o | output | 16 | Code-memory table read address |

## Verification
The next-PC path and the table-address path are evaluated in the same cycle from shared operands. The accumulator and the data pointer feed both the indirect jump and a table read based on the data pointer, and the follow address feeds both a relative branch and a table read based on the PC. The bench drives every branch kind with `tbl_sel_i` toggled and with operand values that carry across the 16-bit boundary. A behavioural model predicts both outputs for every accepted request, and the two outputs are compared on the clock after it. Cycles with `valid_i` low and random inputs confirm that both outputs stay unchanged.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        BR_SEQ   = 3'd0,
        BR_REL   = 3'd1,
        BR_PAGE  = 3'd2,
        BR_LONG  = 3'd3,
        BR_INDIR = 3'd4
    } br_kind_e;
endpackage

// File: rtl/pcu_rel_add.sv
module pcu_rel_add #(
    parameter int AW = 16,
    parameter int OW = 8
) (
    input  logic [AW-1:0] base_i,
    input  logic [OW-1:0] off_i,
    output logic [AW-1:0] sum_o
);
    localparam int EXT_W = AW - OW;

    logic [AW-1:0] off_ext;

    always_comb begin
        off_ext = {{EXT_W{off_i[OW-1]}}, off_i};
        sum_o   = base_i + off_ext;
    end
endmodule

// File: rtl/pcu_zext_add.sv
module pcu_zext_add #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic [AW-1:0] base_i,
    input  logic [DW-1:0] small_i,
    output logic [AW-1:0] sum_o
);
    localparam int PAD_W = AW - DW;

    always_comb begin
        sum_o = base_i + {{PAD_W{1'b0}}, small_i};
    end
endmodule

// File: rtl/pcu_page_splice.sv
module pcu_page_splice #(
    parameter int AW     = 16,
    parameter int PAGE_W = 11,
    parameter int DW     = 8
) (
    input  logic [AW-PAGE_W-1:0] keep_i,
    input  logic [PAGE_W-DW-1:0] hi_i,
    input  logic [DW-1:0]        lo_i,
    output logic [AW-1:0]        tgt_o
);
    always_comb begin
        tgt_o = {keep_i, hi_i, lo_i};
    end
endmodule

// File: rtl/pcu_next_pc.sv
module pcu_next_pc
    import pcu_pkg::*;
#(
    parameter int DW     = 8,
    parameter int PAGE_W = 11
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    valid_i,
    input  logic [KIND_W-1:0]       kind_i,
    input  logic                    taken_i,
    input  logic [2*DW-1:0]         follow_pc_i,
    input  logic [PAGE_W-DW-1:0]    opc_hi_i,
    input  logic [DW-1:0]           op_a_i,
    input  logic [DW-1:0]           op_b_i,
    input  logic [DW-1:0]           acc_i,
    input  logic [2*DW-1:0]         dptr_i,
    input  logic                    tbl_sel_i,
    output logic                    valid_o,
    output logic [2*DW-1:0]         next_pc_o,
    output logic [2*DW-1:0]         tbl_addr_o
);
    localparam int AW   = 2 * DW;
    localparam int HI_W = PAGE_W - DW;

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] next_pc;
        logic [AW-1:0] tbl_addr;
    } pcu_state_t;

    pcu_state_t st_d, st_q;

    logic [AW-1:0] rel_tgt, page_tgt, indir_tgt, tbl_base, tbl_sum;

    pcu_rel_add #(.AW(AW), .OW(DW)) u_rel (
        .base_i (follow_pc_i),
        .off_i  (op_a_i),
        .sum_o  (rel_tgt)
    );

    pcu_page_splice #(.AW(AW), .PAGE_W(PAGE_W), .DW(DW)) u_page (
        .keep_i (follow_pc_i[AW-1:PAGE_W]),
        .hi_i   (opc_hi_i),
        .lo_i   (op_a_i),
        .tgt_o  (page_tgt)
    );

    pcu_zext_add #(.AW(AW), .DW(DW)) u_indir (
        .base_i  (dptr_i),
        .small_i (acc_i),
        .sum_o   (indir_tgt)
    );

    assign tbl_base = tbl_sel_i ? follow_pc_i : dptr_i;

    pcu_zext_add #(.AW(AW), .DW(DW)) u_tbl (
        .base_i  (tbl_base),
        .small_i (acc_i),
        .sum_o   (tbl_sum)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = valid_i;
        if (valid_i) begin
            st_d.tbl_addr = tbl_sum;
            case (kind_i)
                BR_REL:   st_d.next_pc = taken_i ? rel_tgt : follow_pc_i;
                BR_PAGE:  st_d.next_pc = page_tgt;
                BR_LONG:  st_d.next_pc = {op_a_i, op_b_i};
                BR_INDIR: st_d.next_pc = indir_tgt;
                default:  st_d.next_pc = follow_pc_i;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o    = st_q.valid;
    assign next_pc_o  = st_q.next_pc;
    assign tbl_addr_o = st_q.tbl_addr;

    // R2: valid tracks the request one clock later
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);
    a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !valid_o);

    // R10: idle cycles leave both results untouched
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(next_pc_o) && $stable(tbl_addr_o)));

    // R4: not-taken relative branch falls through
    a_r4_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && kind_i == BR_REL && !taken_i) |=> next_pc_o == $past(follow_pc_i));

    // R5: page target keeps the upper bits of the follow address
    a_r5_page_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && kind_i == BR_PAGE) |=>
            next_pc_o[AW-1:PAGE_W] == $past(follow_pc_i[AW-1:PAGE_W]));

    // R6: long target high byte comes from the first operand
    a_r6_long_order: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && kind_i == BR_LONG) |=>
            (next_pc_o[AW-1:DW] == $past(op_a_i) && next_pc_o[DW-1:0] == $past(op_b_i)));

    // R8: unused kinds behave as sequential flow
    a_r8_seq: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (kind_i == BR_SEQ || kind_i > BR_INDIR)) |=>
            next_pc_o == $past(follow_pc_i));
endmodule

// File: tb/sim_pcu_next_pc.sv
module sim_pcu_next_pc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [2:0]  kind_i = '0;
    logic        taken_i = 1'b0;
    logic [15:0] follow_pc_i = '0;
    logic [2:0]  opc_hi_i = '0;
    logic [7:0]  op_a_i = '0;
    logic [7:0]  op_b_i = '0;
    logic [7:0]  acc_i = '0;
    logic [15:0] dptr_i = '0;
    logic        tbl_sel_i = 1'b0;
    logic        valid_o;
    logic [15:0] next_pc_o;
    logic [15:0] tbl_addr_o;

    int checks = 0;
    int errors = 0;
    int exp_pc = 0;
    int exp_tbl = 0;
    int exp_valid = 0;
    string exp_tag = "R1";
    bit done = 1'b0;

    always #4 clk = ~clk;

    pcu_next_pc u0 (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .kind_i(kind_i),
        .taken_i(taken_i), .follow_pc_i(follow_pc_i), .opc_hi_i(opc_hi_i),
        .op_a_i(op_a_i), .op_b_i(op_b_i), .acc_i(acc_i), .dptr_i(dptr_i),
        .tbl_sel_i(tbl_sel_i), .valid_o(valid_o), .next_pc_o(next_pc_o),
        .tbl_addr_o(tbl_addr_o)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural model: computes expectations from the requirements
    task automatic model();
        int off;
        exp_valid = valid_i;
        if (!valid_i) begin
            exp_tag = "R10";
            return;
        end
        exp_tbl = (int'(acc_i) + (tbl_sel_i ? int'(follow_pc_i) : int'(dptr_i))) & 16'hFFFF;
        case (kind_i)
            3'd1: begin
                off = op_a_i >= 128 ? int'(op_a_i) - 256 : int'(op_a_i);
                if (taken_i) begin
                    exp_pc = (int'(follow_pc_i) + off + 65536) % 65536;
                    exp_tag = "R3";
                end else begin
                    exp_pc = follow_pc_i;
                    exp_tag = "R4";
                end
            end
            3'd2: begin
                exp_pc = (int'(follow_pc_i) / 2048) * 2048 + int'(opc_hi_i) * 256 + int'(op_a_i);
                exp_tag = "R5";
            end
            3'd3: begin
                exp_pc = int'(op_a_i) * 256 + int'(op_b_i);
                exp_tag = "R6";
            end
            3'd4: begin
                exp_pc = (int'(dptr_i) + int'(acc_i)) % 65536;
                exp_tag = "R7";
            end
            default: begin
                exp_pc = follow_pc_i;
                exp_tag = "R8";
            end
        endcase
    endtask

    // outputs checked at the negedge after the edge that registered them
    task automatic step(bit v, int k, bit t, int f, int h, int a, int b,
                        int acc, int dp, bit s);
        @(negedge clk);
        valid_i = v; kind_i = 3'(k); taken_i = t; follow_pc_i = 16'(f);
        opc_hi_i = 3'(h); op_a_i = 8'(a); op_b_i = 8'(b); acc_i = 8'(acc);
        dptr_i = 16'(dp); tbl_sel_i = s;
        model();
        @(negedge clk);
        check("R2 valid", int'(valid_o), exp_valid);
        check({exp_tag, " next_pc"}, int'(next_pc_o), exp_pc);
        check({exp_tag == "R10" ? "R10" : "R9", " tbl_addr"}, int'(tbl_addr_o), exp_tbl);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid", int'(valid_o), 0);
        check("R1 next_pc", int'(next_pc_o), 0);
        check("R1 tbl_addr", int'(tbl_addr_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", int'(next_pc_o), 0);

        // R3 wrap downward and upward, plain forward/backward
        step(1, 1, 1, 16'h0001, 0, 8'h80, 0, 8'h10, 16'h1000, 0);
        step(1, 1, 1, 16'hFFF0, 0, 8'h7F, 0, 8'hFF, 16'hFFFF, 1);
        step(1, 1, 1, 16'h1234, 0, 8'hFE, 0, 8'h01, 16'h0000, 0);
        // R4 not taken
        step(1, 1, 0, 16'h4321, 0, 8'h80, 0, 8'h05, 16'h2000, 1);
        // R5 page-absolute at boundaries
        step(1, 2, 0, 16'hF800, 7, 8'hFF, 0, 8'h00, 16'h0000, 0);
        step(1, 2, 1, 16'h07FF, 0, 8'h00, 0, 8'h20, 16'h0100, 1);
        step(1, 2, 0, 16'hABCD, 5, 8'h3C, 0, 8'h00, 16'h0000, 0);
        // R6 long, byte order
        step(1, 3, 0, 16'h0003, 0, 8'h12, 8'h34, 8'h01, 16'h0002, 0);
        // R7 indirect wrap, and R9 table via dptr in the same cycle
        step(1, 4, 0, 16'h0100, 0, 8'h00, 0, 8'h02, 16'hFFFF, 0);
        step(1, 4, 1, 16'h0100, 0, 8'h00, 0, 8'h80, 16'h1F80, 1);
        // R8 sequential kinds ignore taken
        step(1, 0, 1, 16'h5555, 0, 8'h80, 8'h11, 8'h00, 16'h0000, 0);
        step(1, 5, 1, 16'h6666, 0, 8'h80, 8'h11, 8'h00, 16'h0000, 1);
        step(1, 7, 1, 16'h7777, 7, 8'hFF, 8'hFF, 8'hFF, 16'hFFFF, 0);
        // R10 hold with changing inputs
        step(0, 3, 1, 16'h1111, 3, 8'hAA, 8'hBB, 8'hCC, 16'hDDDD, 1);
        step(0, 4, 0, 16'h2222, 1, 8'h01, 8'h02, 8'h03, 16'h0404, 0);

        for (int i = 0; i < 600; i++) begin
            step(($urandom % 8) != 0, $urandom % 8, $urandom % 2, $urandom % 65536,
                 $urandom % 8, $urandom % 256, $urandom % 256, $urandom % 256,
                 $urandom % 65536, $urandom % 2);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule